// File: doc/BRIEF.md
# Two-Wire Master Interrupt Status and Vector Unit

This block gathers the event flags of a two-wire bus master into one 16-bit status register, filters them with a small enable mask, and turns the result into three request lines. The first is a combined interrupt. The other two are DMA requests, one for receive data and one for transmit data. The transfer engine raises status flags by pulsing individual bits of a set vector. Software sees the block through a 16-bit register port that has an offset, a write strobe and a read strobe.

Software can service events in two ways. It can read the status word and write ones to clear the flags that software may clear. Or it can read the vector register: that read returns the number of the lowest pending enabled source and acknowledges that source in the same access. When DMA is switched on for a direction, the block drops the interrupt enable of that direction's ready flag, so the ready event goes to the DMA engine and not to the processor.

Register offsets on `reg_off`:

| Offset | Register |
|---|---|
| 0 | status |
| 1 | enable |
| 2 | vector |
| 3 | DMA config |
| 4 | test (write only) |

All registers return zero after reset.

Top module: `twi_irq_unit`

## Requirements
- R1: `irq` is high exactly when status bits 5..0 ANDed with the enable register are nonzero. The output is registered, so it reflects that AND as it stood one clock earlier.
- R2: `dma_rx_req` follows status bit 3 (receive ready) only while DMA config bit 15 is set. `dma_tx_req` follows status bit 4 (transmit ready) only while DMA config bit 7 is set. Both outputs are registered with the same one-cycle lag as `irq`.
- R3: A write to DMA config (offset 3) stores only bits 15 and 7, and a read returns them in those positions. Writing bit 15 as one clears enable bit 3. Writing bit 7 as one clears enable bit 4.
- R4: A read of the vector register (offset 2) finds the lowest set bit i of (status AND enable) and returns i+1. The same read clears status bit i. With nothing pending it returns 0 and changes nothing.
- R5: A write to status (offset 0) clears only the bits set in both the written value and 0x0027. Ready bits 3 and 4 cannot be cleared by software.
- R6: The enable register (offset 1) keeps 6 bits (mask 0x3f) when `NEW_LAYOUT` is 1, and 5 bits (mask 0x1f) when it is 0.
- R7: A status read returns bit 12 as the live `bus_busy` input ORed into the stored status value.
- R8: A write to the test register (offset 4) with bit 11 set forces status bits 5..0 to one. The same write with bit 11 clear changes no status bit.
- R9: When a set pulse and a software or vector clear hit the same status bit in the same cycle, the set wins.
- R10: After reset, status, enable and DMA config are zero, and `irq`, `dma_rx_req` and `dma_tx_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_off | input | 3 | Register offset for the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a read of the vector register acknowledges a source |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from the addressed register |
| set_pulse | input | 16 | One-cycle status set pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy indication, shown in status bit 12 |
| irq | output | 1 | Combined interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions check on every cycle that the registered request lines track the previous cycle's pending set and DMA gating. They also check that a status write never drops a ready bit, that enabling receive DMA leaves enable bit 3 clear, and that a vector read with a pending source removes exactly one status bit. Only the bench scenarios can show the returned vector values, with several sources pending under many enable masks, across an exhaustive sweep of the six low sources against all 64 enable patterns. The same goes for the priority of a set pulse over a same-cycle clear, the narrower enable mask of the older layout, and the busy bit in status reads.

// File: rtl/twi_irq_pkg.sv
package twi_irq_pkg;
    localparam int DATA_W     = 16;
    localparam int OFF_W      = 3;
    localparam int SRC_N      = 6;
    localparam int SRC_IDX_W  = $clog2(SRC_N);
    localparam int RX_RDY_BIT = 3;
    localparam int TX_RDY_BIT = 4;
    localparam int BUSY_BIT   = 12;
    localparam int RX_DMA_BIT = 15;
    localparam int TX_DMA_BIT = 7;
    localparam int FORCE_BIT  = 11;

    localparam logic [DATA_W-1:0] SW_CLR_MASK = 16'h0027;
    localparam logic [DATA_W-1:0] FORCE_MASK  = 16'h003f;

    typedef enum logic [OFF_W-1:0] {
        OFF_STATUS = 3'd0,
        OFF_ENABLE = 3'd1,
        OFF_VECTOR = 3'd2,
        OFF_DMACFG = 3'd3,
        OFF_TEST   = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [SRC_N-1:0]  enable;
        logic              rx_dma_on;
        logic              tx_dma_on;
    } core_state_t;

    typedef struct packed {
        logic irq;
        logic rx_req;
        logic tx_req;
    } req_state_t;
endpackage

// File: rtl/twi_irq_lowest.sv
module twi_irq_lowest #(
    parameter int W  = 6,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/twi_irq_outstage.sv
module twi_irq_outstage
    import twi_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_N-1:0]    pending_i,
    input  logic                rx_rdy_i,
    input  logic                tx_rdy_i,
    input  logic                rx_dma_on_i,
    input  logic                tx_dma_on_i,
    output logic                irq_o,
    output logic                rx_req_o,
    output logic                tx_req_o
);
    req_state_t req_d, req_q;

    always_comb begin
        req_d.irq    = |pending_i;
        req_d.rx_req = rx_rdy_i & rx_dma_on_i;
        req_d.tx_req = tx_rdy_i & tx_dma_on_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign irq_o    = req_q.irq;
    assign rx_req_o = req_q.rx_req;
    assign tx_req_o = req_q.tx_req;
endmodule

// File: rtl/twi_irq_unit.sv
module twi_irq_unit
    import twi_irq_pkg::*;
#(
    parameter bit NEW_LAYOUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] set_pulse,
    input  logic              bus_busy,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    localparam logic [SRC_N-1:0] EN_MASK = NEW_LAYOUT ? SRC_N'('h3f) : SRC_N'('h1f);

    core_state_t st_d, st_q;
    logic [SRC_N-1:0]     pending;
    logic                 pend_found;
    logic [SRC_IDX_W-1:0] pend_idx;
    logic                 vec_read;

    assign pending  = st_q.status[SRC_N-1:0] & st_q.enable;
    assign vec_read = rd_en && (reg_off == OFF_VECTOR);

    twi_irq_lowest #(.W(SRC_N), .IW(SRC_IDX_W)) u_lowest (
        .vec_i   (pending),
        .found_o (pend_found),
        .idx_o   (pend_idx)
    );

    always_comb begin
        logic [DATA_W-1:0] clr;
        logic [DATA_W-1:0] force_set;
        st_d      = st_q;
        clr       = '0;
        force_set = '0;
        if (wr_en && reg_off == OFF_STATUS) clr = wdata & SW_CLR_MASK;
        if (vec_read && pend_found) clr[pend_idx] = 1'b1;
        if (wr_en && reg_off == OFF_TEST && wdata[FORCE_BIT]) force_set = FORCE_MASK;
        st_d.status = (st_q.status & ~clr) | set_pulse | force_set;

        if (wr_en && reg_off == OFF_ENABLE) st_d.enable = wdata[SRC_N-1:0] & EN_MASK;
        if (wr_en && reg_off == OFF_DMACFG) begin
            st_d.rx_dma_on = wdata[RX_DMA_BIT];
            st_d.tx_dma_on = wdata[TX_DMA_BIT];
            if (wdata[RX_DMA_BIT]) st_d.enable[RX_RDY_BIT] = 1'b0;
            if (wdata[TX_DMA_BIT]) st_d.enable[TX_RDY_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        unique case (reg_off)
            OFF_STATUS: begin
                rdata = st_q.status;
                rdata[BUSY_BIT] = st_q.status[BUSY_BIT] | bus_busy;
            end
            OFF_ENABLE: rdata[SRC_N-1:0] = st_q.enable;
            OFF_VECTOR: rdata = pend_found ? DATA_W'(pend_idx) + DATA_W'(1) : '0;
            OFF_DMACFG: begin
                rdata[RX_DMA_BIT] = st_q.rx_dma_on;
                rdata[TX_DMA_BIT] = st_q.tx_dma_on;
            end
            default: rdata = '0;
        endcase
    end

    twi_irq_outstage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_i   (pending),
        .rx_rdy_i    (st_q.status[RX_RDY_BIT]),
        .tx_rdy_i    (st_q.status[TX_RDY_BIT]),
        .rx_dma_on_i (st_q.rx_dma_on),
        .tx_dma_on_i (st_q.tx_dma_on),
        .irq_o       (irq),
        .rx_req_o    (dma_rx_req),
        .tx_req_o    (dma_tx_req)
    );

    AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|pending)));                                       // R1
    AST_RX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> $past(st_q.status[RX_RDY_BIT] && st_q.rx_dma_on));         // R2
    AST_TX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> $past(st_q.status[TX_RDY_BIT] && st_q.tx_dma_on));         // R2
    AST_RX_DMA_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == OFF_DMACFG && wdata[RX_DMA_BIT]) |=> !st_q.enable[RX_RDY_BIT]); // R3
    AST_VECTOR_ACKS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_read && pending != '0 && set_pulse == '0)
            |=> ($countones(st_q.status) == $past($countones(st_q.status)) - 1)); // R4
    AST_READY_HELD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == OFF_STATUS && st_q.status[RX_RDY_BIT])
            |=> st_q.status[RX_RDY_BIT]);                                         // R5
endmodule

// File: tb/tb_twi_irq_unit.sv
module tb_twi_irq_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_off = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] set_pulse = '0;
    logic        bus_busy = 1'b0;
    logic [15:0] rdata, rdata_old;
    logic        irq, dma_rx_req, dma_tx_req;
    logic        irq_old, rx_old, tx_old;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_irq_unit #(.NEW_LAYOUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .set_pulse(set_pulse), .bus_busy(bus_busy),
        .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    twi_irq_unit #(.NEW_LAYOUT(1'b0)) dut_old (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata_old), .set_pulse(set_pulse), .bus_busy(bus_busy),
        .irq(irq_old), .dma_rx_req(rx_old), .dma_tx_req(tx_old)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [15:0] d);
        @(negedge clk);
        reg_off = off; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [15:0] d);
        @(negedge clk);
        reg_off = off; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v);
        @(negedge clk);
        set_pulse = v;
        @(negedge clk);
        set_pulse = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic drain();
        logic [15:0] tmp;
        wr(3'd1, 16'h003f);
        for (int k = 0; k < 6; k++) rd(3'd2, tmp);
    endtask

    function automatic int lowest_vec(input int v);
        for (int b = 0; b < 6; b++) if (v[b]) return b + 1;
        return 0;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R10 reset state
        rd(3'd0, r); check(r == 16'h0, "R10 status after reset", r, 0);
        rd(3'd1, r); check(r == 16'h0, "R10 enable after reset", r, 0);
        rd(3'd3, r); check(r == 16'h0, "R10 dmacfg after reset", r, 0);
        check({irq, dma_rx_req, dma_tx_req} == 3'b000, "R10 outputs after reset",
              {irq, dma_rx_req, dma_tx_req}, 0);

        // R6 enable width per layout
        wr(3'd1, 16'hffff);
        rd(3'd1, r); check(r == 16'h003f, "R6 enable mask new layout", r, 16'h3f);
        @(negedge clk); reg_off = 3'd1; #1;
        check(rdata_old == 16'h001f, "R6 enable mask old layout", rdata_old, 16'h1f);

        // R4 vector with nothing pending
        rd(3'd2, r); check(r == 16'h0, "R4 empty vector", r, 0);

        // R1/R4 sweep: one source against every enable mask
        for (int i = 0; i < 6; i++) begin
            for (int e = 0; e < 64; e++) begin
                pulse(16'(1 << i));
                wr(3'd1, 16'(e));
                idle();
                check(irq == e[i], "R1 irq vs enable", irq, e[i]);
                wr(3'd1, 16'h003f);
                rd(3'd2, r); check(r == 16'(i + 1), "R4 single vector", r, i + 1);
                rd(3'd0, r); check(r == 16'h0, "R4 ack clears source", r, 0);
                idle();
                check(irq == 1'b0, "R1 irq drops after ack", irq, 0);
            end
        end

        // R4 multiple pending sources
        for (int p = 0; p < 64; p++) begin
            int e, exp_v, exp_s;
            e = (p * 37 + 11) & 63;
            exp_v = lowest_vec(p & e);
            exp_s = (exp_v == 0) ? p : (p & ~(1 << (exp_v - 1)));
            pulse(16'(p));
            wr(3'd1, 16'(e));
            rd(3'd2, r); check(r == 16'(exp_v), "R4 lowest pending vector", r, exp_v);
            rd(3'd0, r); check(r == 16'(exp_s), "R4 status after ack", r, exp_s);
            drain();
        end

        // R5 software clear mask
        pulse(16'h003f);
        wr(3'd0, 16'hffff);
        rd(3'd0, r); check(r == 16'h0018, "R5 status write clears only 0x27", r, 16'h18);
        drain();

        // R9 set beats clear
        @(negedge clk);
        reg_off = 3'd0; wdata = 16'h0001; wr_en = 1'b1; set_pulse = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0; set_pulse = '0; wdata = '0;
        rd(3'd0, r); check(r == 16'h0001, "R9 set wins over clear", r, 1);
        drain();

        // R7 live busy bit
        bus_busy = 1'b1;
        rd(3'd0, r); check(r == 16'h1000, "R7 busy shown in status", r, 16'h1000);
        bus_busy = 1'b0;
        rd(3'd0, r); check(r == 16'h0000, "R7 busy not stored", r, 0);

        // R8 test force
        wr(3'd4, 16'hf7ff);
        rd(3'd0, r); check(r == 16'h0000, "R8 no force without bit 11", r, 0);
        wr(3'd4, 16'h0800);
        rd(3'd0, r); check(r == 16'h003f, "R8 force low six", r, 16'h3f);
        drain();

        // R3 DMA config storage and enable clearing
        wr(3'd1, 16'h003f);
        wr(3'd3, 16'hffff);
        rd(3'd3, r); check(r == 16'h8080, "R3 dmacfg keeps two bits", r, 16'h8080);
        rd(3'd1, r); check(r == 16'h0027, "R3 both enables dropped", r, 16'h27);
        wr(3'd1, 16'h003f);
        wr(3'd3, 16'h0080);
        rd(3'd1, r); check(r == 16'h002f, "R3 tx dma drops enable 4 only", r, 16'h2f);

        // R2 DMA request gating
        wr(3'd3, 16'h8080);
        pulse(16'h0018);
        idle();
        check(dma_rx_req == 1'b1, "R2 rx request on", dma_rx_req, 1);
        check(dma_tx_req == 1'b1, "R2 tx request on", dma_tx_req, 1);
        check(irq == 1'b0, "R1 ready masked after dma enable", irq, 0);
        wr(3'd3, 16'h8000);
        idle();
        check(dma_tx_req == 1'b0, "R2 tx request gated off", dma_tx_req, 0);
        check(dma_rx_req == 1'b1, "R2 rx request stays", dma_rx_req, 1);
        wr(3'd3, 16'h0000);
        idle();
        check(dma_rx_req == 1'b0, "R2 rx request gated off", dma_rx_req, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule